// File: doc/BRIEF.md
# Split Isochronous OUT Transfer Sequencer

This block carries one full-speed isochronous OUT transfer across a high-speed hub as a chain of start-split transactions, each at most 188 bytes, followed by a single complete-split slot. Software loads it with a transfer descriptor. The descriptor holds two 4 KB-aligned page frames, a 12-bit byte offset into the active frame, a page-select flag, the payload-position code, the number of start splits and the total byte count. From then on the block runs once per micro-frame tick and reacts to the start-mask and completion-mask match inputs of that micro-frame.

For each split it issues, the block raises a one-cycle strobe. With the strobe it gives the split kind, the 32-bit buffer address, the payload length and the position label for that payload. It then moves the offset, the split count and the position code forward. When the offset runs past the end of a 4 KB frame, it switches to the second frame. It keeps the updated descriptor fields on write-back outputs, so the schedule engine can store them.

Top module: `sitd_out_seq`

## Requirements
- R1: While reset is asserted and after its release, the issue strobe, active flag, error flag, missed flag, split count, offset and split-state (00) all read zero.
- R2: A load strobe with a split count from 1 to 6 sets the active flag and split-state 00 and places the loaded offset, page select, position and count on the write-back outputs in the next cycle. A count of 0 or above 6 sets the error flag and leaves the transfer inactive.
- R3: A tick with the start mask matching, while active and in split-state 00, gives a one-cycle issue strobe in the next cycle. The strobe carries split kind 0 (start), the address {selected page frame, offset}, a length of the lesser of the remaining bytes and 188, and the current position code (00 All, 01 Begin, 10 Mid, 11 End).
- R4: After each start split, the split count drops by one and the offset advances by the bytes sent, modulo 4096.
- R5: When the offset wraps past 4095 while page select is 0, page select becomes 1, so later addresses use the second frame.
- R6: When the offset wraps while page select is already 1, the error flag is set and the transfer goes inactive.
- R7: A position of Begin becomes Mid after the first start split and becomes End when the count reaches 1. A position of All stays All.
- R8: After the start split that brings the count to 0, the split-state becomes 01 (do complete split).
- R9: A tick with the completion mask matching in split-state 01, with no hold-off, gives an issue strobe of split kind 1 and length 0. It then clears the active flag and returns the split-state to 00.
- R10: A completion-mask match in split-state 01 during a host hold-off sets the missed flag and issues nothing. The transfer stays active and waits for the next match.
- R11: A tick with no matching mask for the current split-state, or any tick while inactive, issues nothing and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Descriptor load strobe |
| ld_page0_i | input | 20 | First page frame, address bits 31:12 |
| ld_page1_i | input | 20 | Second page frame, address bits 31:12 |
| ld_offset_i | input | 12 | Starting byte offset |
| ld_psel_i | input | 1 | Starting page select |
| ld_tpos_i | input | 2 | Starting position code |
| ld_tcount_i | input | 3 | Number of start splits |
| ld_len_i | input | 10 | Total transfer bytes |
| tick_i | input | 1 | Micro-frame tick |
| smask_hit_i | input | 1 | Start mask matches this micro-frame |
| cmask_hit_i | input | 1 | Completion mask matches this micro-frame |
| hold_off_i | input | 1 | Host hold-off blocks the complete split |
| iss_o | output | 1 | One-cycle issue strobe |
| iss_split_o | output | 1 | 0 start split, 1 complete split |
| iss_addr_o | output | 32 | Buffer address of the payload |
| iss_len_o | output | 8 | Payload length in bytes |
| iss_pos_o | output | 2 | Position label of the payload |
| wb_offset_o | output | 12 | Updated offset |
| wb_psel_o | output | 1 | Updated page select |
| wb_tpos_o | output | 2 | Updated position code |
| wb_tcount_o | output | 3 | Remaining start splits |
| wb_sstate_o | output | 2 | Split-state, 00 start, 01 complete |
| wb_active_o | output | 1 | Transfer active |
| wb_missed_o | output | 1 | Complete split missed |
| err_o | output | 1 | Bad count or second page wrap |

## Verification
The bench builds the block with its default parameters: 188-byte payload cap, at most 6 start splits, 10-bit byte count and a 12-bit offset. With these values a 1023-byte transfer needs all six start splits, which exercises the full Begin, Mid, Mid, Mid, Mid, End run. An offset placed near 4095 makes the frame switch happen between two splits. Loading page select 1 with an offset near the top of the frame brings the error on a second wrap within a single split.

// File: rtl/sitd_pkg.sv
package sitd_pkg;
  typedef enum logic [1:0] {
    TP_ALL   = 2'b00,
    TP_BEGIN = 2'b01,
    TP_MID   = 2'b10,
    TP_END   = 2'b11
  } tpos_e;

  typedef enum logic [1:0] {
    SS_DO_START    = 2'b00,
    SS_DO_COMPLETE = 2'b01
  } sstate_e;

  localparam logic SPLIT_START    = 1'b0;
  localparam logic SPLIT_COMPLETE = 1'b1;
endpackage

// File: rtl/sitd_chunk.sv
// Picks the payload length of the next start split and the bytes left after it.
module sitd_chunk #(
  parameter int XFER_W      = 10,
  parameter int PLEN_W      = 8,
  parameter int MAX_PAYLOAD = 188
) (
  input  logic [XFER_W-1:0] rem_i,
  output logic [PLEN_W-1:0] len_o,
  output logic [XFER_W-1:0] rem_nxt_o
);
  localparam logic [XFER_W-1:0] CAP = XFER_W'(MAX_PAYLOAD);

  always_comb begin
    if (rem_i > CAP) len_o = PLEN_W'(MAX_PAYLOAD);
    else             len_o = rem_i[PLEN_W-1:0];
    rem_nxt_o = rem_i - XFER_W'(len_o);
  end
endmodule

// File: rtl/sitd_addr_gen.sv
// Forms the buffer address and advances the offset, flagging a frame wrap.
module sitd_addr_gen #(
  parameter int PTR_W  = 20,
  parameter int OFF_W  = 12,
  parameter int PLEN_W = 8
) (
  input  logic [PTR_W-1:0]       page0_i,
  input  logic [PTR_W-1:0]       page1_i,
  input  logic                   psel_i,
  input  logic [OFF_W-1:0]       offset_i,
  input  logic [PLEN_W-1:0]      len_i,
  output logic [PTR_W+OFF_W-1:0] addr_o,
  output logic [OFF_W-1:0]       offset_nxt_o,
  output logic                   wrap_o
);
  logic [OFF_W:0] sum;

  always_comb begin
    addr_o       = {(psel_i ? page1_i : page0_i), offset_i};
    sum          = {1'b0, offset_i} + (OFF_W+1)'(len_i);
    offset_nxt_o = sum[OFF_W-1:0];
    wrap_o       = sum[OFF_W];
  end
endmodule

// File: rtl/sitd_pos_next.sv
// Steps the split count and the payload position code after a start split.
module sitd_pos_next
  import sitd_pkg::*;
#(
  parameter int TC_W = 3
) (
  input  tpos_e           tpos_i,
  input  logic [TC_W-1:0] tcount_i,
  output tpos_e           tpos_nxt_o,
  output logic [TC_W-1:0] tcount_nxt_o,
  output logic            last_o
);
  always_comb begin
    tcount_nxt_o = tcount_i - TC_W'(1);
    last_o       = (tcount_i == TC_W'(1));
    tpos_nxt_o   = tpos_i;
    if (tpos_i != TP_ALL) begin
      if (tcount_nxt_o == TC_W'(1))     tpos_nxt_o = TP_END;
      else if (tcount_nxt_o > TC_W'(1)) tpos_nxt_o = TP_MID;
    end
  end
endmodule

// File: rtl/sitd_out_seq.sv
module sitd_out_seq
  import sitd_pkg::*;
#(
  parameter int PTR_W       = 20,
  parameter int OFF_W       = 12,
  parameter int XFER_W      = 10,
  parameter int TC_W        = 3,
  parameter int MAX_PAYLOAD = 188,
  parameter int MAX_TCOUNT  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [PTR_W-1:0]       ld_page0_i,
  input  logic [PTR_W-1:0]       ld_page1_i,
  input  logic [OFF_W-1:0]       ld_offset_i,
  input  logic                   ld_psel_i,
  input  logic [1:0]             ld_tpos_i,
  input  logic [TC_W-1:0]        ld_tcount_i,
  input  logic [XFER_W-1:0]      ld_len_i,
  input  logic                   tick_i,
  input  logic                   smask_hit_i,
  input  logic                   cmask_hit_i,
  input  logic                   hold_off_i,
  output logic                   iss_o,
  output logic                   iss_split_o,
  output logic [PTR_W+OFF_W-1:0] iss_addr_o,
  output logic [$clog2(MAX_PAYLOAD+1)-1:0] iss_len_o,
  output logic [1:0]             iss_pos_o,
  output logic [OFF_W-1:0]       wb_offset_o,
  output logic                   wb_psel_o,
  output logic [1:0]             wb_tpos_o,
  output logic [TC_W-1:0]        wb_tcount_o,
  output logic [1:0]             wb_sstate_o,
  output logic                   wb_active_o,
  output logic                   wb_missed_o,
  output logic                   err_o
);
  localparam int ADDR_W = PTR_W + OFF_W;
  localparam int PLEN_W = $clog2(MAX_PAYLOAD + 1);

  // descriptor state
  logic [PTR_W-1:0]  page0_q, page0_d, page1_q, page1_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              psel_q, psel_d;
  tpos_e             tpos_q, tpos_d;
  logic [TC_W-1:0]   tc_q, tc_d;
  sstate_e           ss_q, ss_d;
  logic              active_q, active_d;
  logic              missed_q, missed_d;
  logic              err_q, err_d;
  logic [XFER_W-1:0] rem_q, rem_d;
  // issue bundle
  logic              iss_q, iss_d;
  logic              split_q, split_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PLEN_W-1:0] len_q, len_d;
  tpos_e             pos_q, pos_d;

  logic [PLEN_W-1:0] chunk_len;
  logic [XFER_W-1:0] rem_nxt;
  logic [ADDR_W-1:0] cur_addr;
  logic [OFF_W-1:0]  off_nxt;
  logic              wrap;
  tpos_e             tpos_nxt;
  logic [TC_W-1:0]   tc_nxt;
  logic              last_start;
  logic              start_go, cs_slot, ld_ok, desc_en;

  sitd_chunk #(.XFER_W(XFER_W), .PLEN_W(PLEN_W), .MAX_PAYLOAD(MAX_PAYLOAD)) u_chunk (
    .rem_i(rem_q), .len_o(chunk_len), .rem_nxt_o(rem_nxt)
  );

  sitd_addr_gen #(.PTR_W(PTR_W), .OFF_W(OFF_W), .PLEN_W(PLEN_W)) u_addr (
    .page0_i(page0_q), .page1_i(page1_q), .psel_i(psel_q), .offset_i(off_q),
    .len_i(chunk_len), .addr_o(cur_addr), .offset_nxt_o(off_nxt), .wrap_o(wrap)
  );

  sitd_pos_next #(.TC_W(TC_W)) u_pos (
    .tpos_i(tpos_q), .tcount_i(tc_q), .tpos_nxt_o(tpos_nxt),
    .tcount_nxt_o(tc_nxt), .last_o(last_start)
  );

  assign start_go = tick_i & smask_hit_i & active_q & (ss_q == SS_DO_START) & (tc_q != '0);
  assign cs_slot  = tick_i & cmask_hit_i & active_q & (ss_q == SS_DO_COMPLETE);
  assign ld_ok    = (ld_tcount_i != '0) && (ld_tcount_i <= TC_W'(MAX_TCOUNT));
  assign desc_en  = load_i | tick_i;

  always_comb begin
    page0_d  = page0_q;
    page1_d  = page1_q;
    off_d    = off_q;
    psel_d   = psel_q;
    tpos_d   = tpos_q;
    tc_d     = tc_q;
    ss_d     = ss_q;
    active_d = active_q;
    missed_d = missed_q;
    err_d    = err_q;
    rem_d    = rem_q;
    iss_d    = 1'b0;
    split_d  = split_q;
    addr_d   = addr_q;
    len_d    = len_q;
    pos_d    = pos_q;
    if (load_i) begin
      page0_d  = ld_page0_i;
      page1_d  = ld_page1_i;
      off_d    = ld_offset_i;
      psel_d   = ld_psel_i;
      tpos_d   = tpos_e'(ld_tpos_i);
      tc_d     = ld_tcount_i;
      rem_d    = ld_len_i;
      ss_d     = SS_DO_START;
      missed_d = 1'b0;
      active_d = ld_ok;
      err_d    = ~ld_ok;
    end else if (start_go) begin
      iss_d   = 1'b1;
      split_d = SPLIT_START;
      addr_d  = cur_addr;
      len_d   = chunk_len;
      pos_d   = tpos_q;
      off_d   = off_nxt;
      tc_d    = tc_nxt;
      tpos_d  = tpos_nxt;
      rem_d   = rem_nxt;
      if (wrap && psel_q) begin
        err_d    = 1'b1;
        active_d = 1'b0;
      end else begin
        if (wrap)       psel_d = 1'b1;
        if (last_start) ss_d   = SS_DO_COMPLETE;
      end
    end else if (cs_slot) begin
      if (hold_off_i) begin
        missed_d = 1'b1;
      end else begin
        iss_d    = 1'b1;
        split_d  = SPLIT_COMPLETE;
        addr_d   = cur_addr;
        len_d    = '0;
        pos_d    = tpos_q;
        active_d = 1'b0;
        ss_d     = SS_DO_START;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page0_q  <= '0;
      page1_q  <= '0;
      off_q    <= '0;
      psel_q   <= 1'b0;
      tpos_q   <= TP_ALL;
      tc_q     <= '0;
      ss_q     <= SS_DO_START;
      active_q <= 1'b0;
      missed_q <= 1'b0;
      err_q    <= 1'b0;
      rem_q    <= '0;
    end else if (desc_en) begin
      page0_q  <= page0_d;
      page1_q  <= page1_d;
      off_q    <= off_d;
      psel_q   <= psel_d;
      tpos_q   <= tpos_d;
      tc_q     <= tc_d;
      ss_q     <= ss_d;
      active_q <= active_d;
      missed_q <= missed_d;
      err_q    <= err_d;
      rem_q    <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_q   <= 1'b0;
      split_q <= SPLIT_START;
      addr_q  <= '0;
      len_q   <= '0;
      pos_q   <= TP_ALL;
    end else begin
      iss_q   <= iss_d;
      split_q <= split_d;
      addr_q  <= addr_d;
      len_q   <= len_d;
      pos_q   <= pos_d;
    end
  end

  assign iss_o       = iss_q;
  assign iss_split_o = split_q;
  assign iss_addr_o  = addr_q;
  assign iss_len_o   = len_q;
  assign iss_pos_o   = pos_q;
  assign wb_offset_o = off_q;
  assign wb_psel_o   = psel_q;
  assign wb_tpos_o   = tpos_q;
  assign wb_tcount_o = tc_q;
  assign wb_sstate_o = ss_q;
  assign wb_active_o = active_q;
  assign wb_missed_o = missed_q;
  assign err_o       = err_q;
endmodule

// File: rtl/sitd_out_seq_chk.sv
module sitd_out_seq_chk #(
  parameter int TC_W        = 3,
  parameter int PLEN_W      = 8,
  parameter int MAX_PAYLOAD = 188
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              tick_i,
  input logic              smask_hit_i,
  input logic              cmask_hit_i,
  input logic              hold_off_i,
  input logic              iss_o,
  input logic              iss_split_o,
  input logic [PLEN_W-1:0] iss_len_o,
  input logic              wb_psel_o,
  input logic [TC_W-1:0]   wb_tcount_o,
  input logic              wb_active_o
);
  a_r3_issue_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    iss_o |-> $past(tick_i));

  a_r3_start_needs_smask: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_o && !iss_split_o) |-> $past(smask_hit_i));

  a_r3_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
    iss_o |-> (iss_len_o <= PLEN_W'(MAX_PAYLOAD)));

  a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_o && !iss_split_o) |-> (wb_tcount_o == $past(wb_tcount_o) - TC_W'(1)));

  a_r5_psel_falls_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wb_psel_o) |-> $past(load_i));

  a_r9_complete_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_o && iss_split_o) |-> !wb_active_o);

  a_r10_holdoff_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_o && iss_split_o) |-> ($past(cmask_hit_i) && !$past(hold_off_i)));
endmodule

bind sitd_out_seq sitd_out_seq_chk #(
  .TC_W(TC_W), .PLEN_W($clog2(MAX_PAYLOAD+1)), .MAX_PAYLOAD(MAX_PAYLOAD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .tick_i(tick_i),
  .smask_hit_i(smask_hit_i), .cmask_hit_i(cmask_hit_i), .hold_off_i(hold_off_i),
  .iss_o(iss_o), .iss_split_o(iss_split_o), .iss_len_o(iss_len_o),
  .wb_psel_o(wb_psel_o), .wb_tcount_o(wb_tcount_o), .wb_active_o(wb_active_o)
);

// File: tb/sitd_out_seq_test.sv
module sitd_out_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [19:0] ld_page0_i = '0, ld_page1_i = '0;
  logic [11:0] ld_offset_i = '0;
  logic        ld_psel_i = 1'b0;
  logic [1:0]  ld_tpos_i = '0;
  logic [2:0]  ld_tcount_i = '0;
  logic [9:0]  ld_len_i = '0;
  logic        tick_i = 1'b0, smask_hit_i = 1'b0, cmask_hit_i = 1'b0, hold_off_i = 1'b0;
  logic        iss_o, iss_split_o;
  logic [31:0] iss_addr_o;
  logic [7:0]  iss_len_o;
  logic [1:0]  iss_pos_o;
  logic [11:0] wb_offset_o;
  logic        wb_psel_o;
  logic [1:0]  wb_tpos_o;
  logic [2:0]  wb_tcount_o;
  logic [1:0]  wb_sstate_o;
  logic        wb_active_o, wb_missed_o, err_o;

  int checks = 0;
  int errors = 0;

  localparam logic [19:0] P0 = 20'hAAAAA;
  localparam logic [19:0] P1 = 20'h55555;

  always #5 clk = ~clk;

  sitd_out_seq uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i),
    .ld_page0_i(ld_page0_i), .ld_page1_i(ld_page1_i), .ld_offset_i(ld_offset_i),
    .ld_psel_i(ld_psel_i), .ld_tpos_i(ld_tpos_i), .ld_tcount_i(ld_tcount_i),
    .ld_len_i(ld_len_i), .tick_i(tick_i), .smask_hit_i(smask_hit_i),
    .cmask_hit_i(cmask_hit_i), .hold_off_i(hold_off_i),
    .iss_o(iss_o), .iss_split_o(iss_split_o), .iss_addr_o(iss_addr_o),
    .iss_len_o(iss_len_o), .iss_pos_o(iss_pos_o),
    .wb_offset_o(wb_offset_o), .wb_psel_o(wb_psel_o), .wb_tpos_o(wb_tpos_o),
    .wb_tcount_o(wb_tcount_o), .wb_sstate_o(wb_sstate_o),
    .wb_active_o(wb_active_o), .wb_missed_o(wb_missed_o), .err_o(err_o)
  );

  // offset, psel, tpos, tcount, length, final offset, final psel
  typedef struct packed {
    logic [11:0] off;
    logic        psel;
    logic [1:0]  tpos;
    logic [2:0]  tc;
    logic [9:0]  len;
    logic [11:0] fin_off;
    logic        fin_psel;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{12'h100, 1'b0, 2'b00, 3'd1, 10'd100,  12'h164, 1'b0},
    '{12'h000, 1'b0, 2'b01, 3'd3, 10'd400,  12'h190, 1'b0},
    '{12'hF80, 1'b0, 2'b01, 3'd2, 10'd376,  12'h0F8, 1'b1},
    '{12'h000, 1'b0, 2'b01, 3'd6, 10'd1023, 12'h3FF, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [11:0] off, input logic psel, input logic [1:0] tp,
                         input logic [2:0] tc, input logic [9:0] len);
    @(negedge clk);
    load_i = 1'b1; ld_page0_i = P0; ld_page1_i = P1; ld_offset_i = off;
    ld_psel_i = psel; ld_tpos_i = tp; ld_tcount_i = tc; ld_len_i = len;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_tick(input logic sm, input logic cm, input logic ho);
    @(negedge clk);
    tick_i = 1'b1; smask_hit_i = sm; cmask_hit_i = cm; hold_off_i = ho;
    @(negedge clk);
    tick_i = 1'b0; smask_hit_i = 1'b0; cmask_hit_i = 1'b0; hold_off_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 iss", iss_o, 0);
    check("R1 active", wb_active_o, 0);
    check("R1 err", err_o, 0);
    check("R1 sstate", wb_sstate_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tcount after release", wb_tcount_o, 0);

    foreach (VECS[i]) begin
      logic [11:0] off;
      logic        psel;
      logic [1:0]  pos;
      int          tc, rem, elen, sum;
      do_load(VECS[i].off, VECS[i].psel, VECS[i].tpos, VECS[i].tc, VECS[i].len);
      check("R2 active", wb_active_o, 1);
      check("R2 tcount", wb_tcount_o, VECS[i].tc);
      off = VECS[i].off; psel = VECS[i].psel; pos = VECS[i].tpos;
      tc = VECS[i].tc; rem = VECS[i].len;
      for (int k = 0; k < VECS[i].tc; k++) begin
        do_tick(1'b1, 1'b0, 1'b0);
        elen = (rem > 188) ? 188 : rem;
        check("R3 strobe", iss_o, 1);
        check("R3 kind", iss_split_o, 0);
        check("R3 addr", iss_addr_o, {(psel ? P1 : P0), off});
        check("R3 len", iss_len_o, elen);
        check("R7 pos", iss_pos_o, pos);
        sum = off + elen;
        if (sum >= 4096) psel = 1'b1;
        off = sum[11:0];
        rem = rem - elen;
        tc = tc - 1;
        if (pos != 2'b00) begin
          if (tc == 1) pos = 2'b11;
          else if (tc > 1) pos = 2'b10;
        end
        check("R4 tcount", wb_tcount_o, tc);
        check("R4 offset", wb_offset_o, off);
        check("R7 wb tpos", wb_tpos_o, pos);
        @(negedge clk);
        check("R3 one cycle", iss_o, 0);
      end
      check("R4 final offset", wb_offset_o, VECS[i].fin_off);
      check("R5 final psel", wb_psel_o, VECS[i].fin_psel);
      check("R8 sstate complete", wb_sstate_o, 1);
      do_tick(1'b0, 1'b1, 1'b0);
      check("R9 strobe", iss_o, 1);
      check("R9 kind", iss_split_o, 1);
      check("R9 len", iss_len_o, 0);
      check("R9 inactive", wb_active_o, 0);
      check("R9 sstate", wb_sstate_o, 0);
    end

    // R2: count above 6 and count 0
    do_load(12'h0, 1'b0, 2'b00, 3'd7, 10'd50);
    check("R2 err on 7", err_o, 1);
    check("R2 inactive on 7", wb_active_o, 0);
    do_tick(1'b1, 1'b0, 1'b0);
    check("R11 inactive no issue", iss_o, 0);
    do_load(12'h0, 1'b0, 2'b00, 3'd0, 10'd50);
    check("R2 err on 0", err_o, 1);

    // R11: non-matching ticks
    do_load(12'h010, 1'b0, 2'b01, 3'd2, 10'd300);
    check("R2 err cleared", err_o, 0);
    do_tick(1'b0, 1'b0, 1'b0);
    check("R11 no smask no issue", iss_o, 0);
    check("R11 count held", wb_tcount_o, 2);
    do_tick(1'b0, 1'b1, 1'b0);
    check("R11 cmask in start state", iss_o, 0);
    check("R11 count held cm", wb_tcount_o, 2);
    do_tick(1'b1, 1'b0, 1'b0);
    do_tick(1'b1, 1'b0, 1'b0);
    check("R8 sstate", wb_sstate_o, 1);

    // R10: hold-off during completion slot
    do_tick(1'b0, 1'b1, 1'b1);
    check("R10 no issue", iss_o, 0);
    check("R10 missed", wb_missed_o, 1);
    check("R10 still active", wb_active_o, 1);
    do_tick(1'b0, 1'b1, 1'b0);
    check("R10 later complete", iss_o, 1);
    check("R10 then retired", wb_active_o, 0);

    // R6: wrap while second page already selected
    do_load(12'hFF0, 1'b1, 2'b00, 3'd1, 10'd100);
    do_tick(1'b1, 1'b0, 1'b0);
    check("R6 strobe", iss_o, 1);
    check("R6 addr", iss_addr_o, {P1, 12'hFF0});
    check("R6 err", err_o, 1);
    check("R6 inactive", wb_active_o, 0);
    do_tick(1'b0, 1'b1, 1'b0);
    check("R6 no complete", iss_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule